// File: doc/BRIEF.md
# Debug Access Authorization Controller

This block decides which debug sub-domains and debug commands are open on a device. A configuration vector, fixed at manufacture, gives every enable a two-bit policy: closed for good, open for good, or open only after a successful authentication. The enables cover secure and non-secure invasive and non-invasive debug, the test access port, invasive and non-invasive debug of a second core, and three command enables for a boot-time programming command, a field-return analysis command and a flash mass-erase command.

Authentication is a challenge/response exchange driven through a mailbox. A start request makes the block ask an external random source for a 128-bit challenge. It then presents that challenge together with the device's debug policy vector, and waits a programmable number of cycles for the debugger's response. When the response arrives, the block hands the verification to an external verifier and waits for its verdict, its credential mask and the device ID named in the credential. An enable with the authenticated policy opens only when the verdict passes and the credential mask has that enable's bit set. Signature checking and random number generation sit outside the block and are reached only through request/valid handshakes.

Top module: `dbg_access_gate`

## Requirements
- R1: An enable whose policy code is 2'b00 or 2'b10 is low at all times, including after a passed authentication.
- R2: An enable whose policy code is 2'b11 is high from the first cycle after reset, whether or not authentication has taken place.
- R3: An enable whose policy code is 2'b01 goes high only after a passed verification whose credential mask has that enable's bit set, and it is low before that.
- R4: A start request accepted in idle raises `rng_req` the next cycle. Once `rng_valid` is seen, `chal_valid` rises the next cycle, with `chal_data` equal to the random word that was returned and `chal_policy` equal to `pol_cfg`.
- R5: A response seen while the challenge is presented raises `ver_req` the next cycle, and `ver_req` stays high until `ver_done` is seen.
- R6: A failed verdict sends the block back to idle with `err` high and no authenticated enable opened. `err` stays high until the next accepted start request, which clears it in the following cycle.
- R7: When `id_check_en` is high, a passing verdict whose `ver_id` differs from `dev_id` is treated as a failure. When `id_check_en` is low, `ver_id` is ignored.
- R8: The challenge is held for at most `timeout_cycles`+1 cycles. A response arriving while fewer than `timeout_cycles` cycles of the challenge have passed is accepted. Without one, the exchange aborts in the same way as a failed verdict.
- R9: Once authenticated, the block keeps `auth_ok` and its granted enables until reset, and a further start request raises no `rng_req`.
- R10: At most one of `rng_req`, `chal_valid` and `ver_req` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pol_cfg | input | 2*NDOM | Policy of enable i in bits [2i+1:2i]: 00 closed, 01 after authentication, 11 open, 10 closed |
| id_check_en | input | 1 | Require the credential ID to match the device ID |
| dev_id | input | IDW | Device unique ID |
| timeout_cycles | input | TOUT_W | Response timeout in cycles |
| start_req | input | 1 | Mailbox start request |
| rng_req | output | 1 | Request to the random source |
| rng_valid | input | 1 | Random word valid |
| rng_data | input | CHAL_W | Random word |
| chal_valid | output | 1 | Challenge presented to the mailbox |
| chal_data | output | CHAL_W | Random part of the challenge |
| chal_policy | output | 2*NDOM | Policy part of the challenge |
| resp_valid | input | 1 | Debugger response has arrived |
| ver_req | output | 1 | Request to the verifier |
| ver_done | input | 1 | Verdict valid |
| ver_pass | input | 1 | Signature and challenge verified |
| ver_mask | input | NDOM | Enables allowed by the credential |
| ver_id | input | IDW | Device ID named in the credential |
| dom_en | output | NDOM | Debug domain and command enables |
| auth_ok | output | 1 | Authentication has succeeded |
| err | output | 1 | Last exchange failed or timed out |

## Verification
The assertions check on every cycle that closed policies keep their enables low, that permanent policies keep theirs high, and that an authenticated-policy enable is never high without `auth_ok`. They also check that the three handshakes never overlap, that a verifier request is held until its verdict, that the challenge never outlives the timeout, and that `auth_ok` and `err` are sticky. Only the bench scenarios can show which enables open for a given credential mask, that an ID mismatch is rejected only when the check is enforced, that the challenge carries the returned random word, and that a response in the last allowed cycle is still accepted.

// File: rtl/dbg_access_gate.sv
module dbg_access_gate #(
  parameter int NDOM   = 10,
  parameter int CHAL_W = 128,
  parameter int IDW    = 16,
  parameter int TOUT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2*NDOM-1:0] pol_cfg,
  input  logic              id_check_en,
  input  logic [IDW-1:0]    dev_id,
  input  logic [TOUT_W-1:0] timeout_cycles,
  input  logic              start_req,
  output logic              rng_req,
  input  logic              rng_valid,
  input  logic [CHAL_W-1:0] rng_data,
  output logic              chal_valid,
  output logic [CHAL_W-1:0] chal_data,
  output logic [2*NDOM-1:0] chal_policy,
  input  logic              resp_valid,
  output logic              ver_req,
  input  logic              ver_done,
  input  logic              ver_pass,
  input  logic [NDOM-1:0]   ver_mask,
  input  logic [IDW-1:0]    ver_id,
  output logic [NDOM-1:0]   dom_en,
  output logic              auth_ok,
  output logic              err
);
  typedef enum logic [1:0] {S_IDLE, S_RNG, S_WAIT, S_VER} st_t;

  st_t               st;
  logic [TOUT_W-1:0] cnt;
  logic [CHAL_W-1:0] chal_q;
  logic [NDOM-1:0]   grant_q;
  logic              auth_q, err_q;
  logic              verdict_ok;

  assign verdict_ok  = ver_pass && (!id_check_en || ver_id == dev_id);
  assign rng_req     = (st == S_RNG);
  assign chal_valid  = (st == S_WAIT);
  assign ver_req     = (st == S_VER);
  assign chal_data   = chal_q;
  assign chal_policy = pol_cfg;
  assign auth_ok     = auth_q;
  assign err         = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      chal_q  <= '0;
      grant_q <= '0;
      auth_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start_req && !auth_q) begin
          st    <= S_RNG;
          err_q <= 1'b0;
        end
        S_RNG: if (rng_valid) begin
          chal_q <= rng_data;
          cnt    <= '0;
          st     <= S_WAIT;
        end
        S_WAIT: begin
          if (cnt >= timeout_cycles) begin
            st    <= S_IDLE;
            err_q <= 1'b1;
          end else if (resp_valid) begin
            st <= S_VER;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_VER: if (ver_done) begin
          st <= S_IDLE;
          if (verdict_ok) begin
            auth_q  <= 1'b1;
            grant_q <= ver_mask;
          end else begin
            err_q <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  for (genvar i = 0; i < NDOM; i++) begin : g_en
    logic [1:0] pol;
    assign pol       = pol_cfg[2*i +: 2];
    assign dom_en[i] = (pol == 2'b11) || (pol == 2'b01 && auth_q && grant_q[i]);
  end
endmodule

// File: rtl/dbg_access_gate_chk.sv
module dbg_access_gate_chk #(
  parameter int NDOM   = 10,
  parameter int TOUT_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2*NDOM-1:0] pol_cfg,
  input logic [TOUT_W-1:0] timeout_cycles,
  input logic              start_req,
  input logic              rng_req,
  input logic              rng_valid,
  input logic              chal_valid,
  input logic              ver_req,
  input logic              ver_done,
  input logic [NDOM-1:0]   dom_en,
  input logic              auth_ok,
  input logic              err
);
  logic [TOUT_W:0] run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run <= '0;
    else        run <= chal_valid ? run + 1'b1 : '0;
  end

  for (genvar i = 0; i < NDOM; i++) begin : g_dom
    assert_disabled_closed_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (pol_cfg[2*i +: 2] == 2'b00 || pol_cfg[2*i +: 2] == 2'b10) |-> !dom_en[i]);
    assert_permanent_open_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (pol_cfg[2*i +: 2] == 2'b11) |-> dom_en[i]);
    assert_auth_needed_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (pol_cfg[2*i +: 2] == 2'b01 && dom_en[i]) |-> auth_ok);
  end

  assert_chal_follows_rng_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rng_req && rng_valid) |=> chal_valid);
  assert_ver_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ver_req && !ver_done) |=> ver_req);
  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !start_req) |=> err);
  assert_err_without_auth_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> !auth_ok);
  assert_chal_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    chal_valid |-> (run <= {1'b0, timeout_cycles}));
  assert_auth_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    auth_ok |=> auth_ok);
  assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (auth_ok && start_req) |=> !rng_req);
  assert_one_handshake_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rng_req, chal_valid, ver_req}));
endmodule

bind dbg_access_gate dbg_access_gate_chk #(.NDOM(NDOM), .TOUT_W(TOUT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pol_cfg(pol_cfg), .timeout_cycles(timeout_cycles),
  .start_req(start_req), .rng_req(rng_req), .rng_valid(rng_valid),
  .chal_valid(chal_valid), .ver_req(ver_req), .ver_done(ver_done),
  .dom_en(dom_en), .auth_ok(auth_ok), .err(err)
);

// File: tb/dbg_access_gate_test.sv
module dbg_access_gate_test;
  localparam int NDOM = 10;
  localparam int CW   = 128;
  localparam int IDW  = 16;
  localparam int TW   = 16;
  localparam int TOUT = 3;
  localparam logic [IDW-1:0] DEV = 16'hA5C3;

  logic clk = 0, rst_n = 0;
  logic [2*NDOM-1:0] pol_cfg = '0;
  logic id_check_en = 0;
  logic [IDW-1:0] dev_id = DEV;
  logic [TW-1:0] timeout_cycles = TOUT;
  logic start_req = 0, rng_valid = 0, resp_valid = 0;
  logic ver_done = 0, ver_pass = 0;
  logic [CW-1:0] rng_data = '0;
  logic [NDOM-1:0] ver_mask = '0;
  logic [IDW-1:0] ver_id = '0;
  logic rng_req, chal_valid, ver_req, auth_ok, err;
  logic [CW-1:0] chal_data;
  logic [2*NDOM-1:0] chal_policy;
  logic [NDOM-1:0] dom_en;

  int total = 0, bad = 0;

  always #10 clk = ~clk;

  dbg_access_gate #(.NDOM(NDOM), .CHAL_W(CW), .IDW(IDW), .TOUT_W(TW)) uut (.*);

  task automatic chk(input bit ok, input string tag, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [NDOM-1:0] exp_en(logic [2*NDOM-1:0] p, bit a, logic [NDOM-1:0] m);
    logic [NDOM-1:0] r;
    for (int i = 0; i < NDOM; i++)
      r[i] = (p[2*i +: 2] == 2'b11) || (p[2*i +: 2] == 2'b01 && a && m[i]);
    return r;
  endfunction

  function automatic logic [2*NDOM-1:0] make_pol(int c);
    logic [2*NDOM-1:0] r;
    for (int i = 0; i < NDOM; i++)
      r[2*i +: 2] = (c < 4) ? 2'((i + c) % 4) : 2'(c - 4);
    return r;
  endfunction

  task automatic begin_exchange(input logic [CW-1:0] rnd);
    @(negedge clk) start_req = 1;
    @(negedge clk) start_req = 0;
    chk(rng_req == 1'b1, "R4 rng_req after start", CW'(rng_req), 1);
    chk(err == 1'b0, "R6 err cleared by start", CW'(err), 0);
    rng_valid = 1; rng_data = rnd;
    @(negedge clk) rng_valid = 0;
    chk(chal_valid && chal_data == rnd, "R4 challenge data", chal_data, rnd);
    chk(chal_policy == pol_cfg, "R4 challenge policy", CW'(chal_policy), CW'(pol_cfg));
  endtask

  task automatic exchange(input logic [NDOM-1:0] m, input bit pass, input logic [IDW-1:0] id,
                          input int delay, input logic [CW-1:0] rnd);
    begin_exchange(rnd);
    repeat (delay) @(negedge clk);
    resp_valid = 1;
    @(negedge clk) resp_valid = 0;
    chk(ver_req == 1'b1, "R5 ver_req after response", CW'(ver_req), 1);
    @(negedge clk);
    chk(ver_req == 1'b1, "R5 ver_req held", CW'(ver_req), 1);
    ver_done = 1; ver_pass = pass; ver_mask = m; ver_id = id;
    @(negedge clk) ver_done = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < 8; c++) begin
      logic [NDOM-1:0] m;
      logic [NDOM-1:0] none;
      logic [CW-1:0] rnd;
      bit idc;
      m = NDOM'(10'h2B5 ^ (c * 37));
      none = '0;
      rnd = {4{32'h9E3779B9 * (c + 1)}};
      idc = c[0];
      rst_n = 0;
      pol_cfg = make_pol(c);
      id_check_en = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk(dom_en == exp_en(pol_cfg, 0, none), "R1 R2 reset enables", CW'(dom_en), CW'(exp_en(pol_cfg, 0, none)));
      chk(!auth_ok && !err && !rng_req && !chal_valid && !ver_req, "R10 reset idle",
          CW'({auth_ok, err, rng_req, chal_valid, ver_req}), 0);

      exchange('1, 0, DEV, 1, rnd);
      chk(err && !auth_ok, "R6 failed verdict", CW'({err, auth_ok}), CW'(2'b10));
      chk(dom_en == exp_en(pol_cfg, 0, none), "R6 no grant on fail", CW'(dom_en), CW'(exp_en(pol_cfg, 0, none)));

      id_check_en = 1;
      exchange('1, 1, DEV ^ 16'h0100, 0, ~rnd);
      chk(err && !auth_ok, "R7 id mismatch rejected", CW'({err, auth_ok}), CW'(2'b10));
      chk(dom_en == exp_en(pol_cfg, 0, none), "R7 no grant on mismatch", CW'(dom_en), CW'(exp_en(pol_cfg, 0, none)));

      begin_exchange(rnd ^ 128'h5);
      repeat (TOUT) @(negedge clk);
      chk(chal_valid == 1'b1, "R8 challenge held to timeout", CW'(chal_valid), 1);
      @(negedge clk);
      chk(err && !chal_valid && !auth_ok, "R8 timeout abort", CW'({err, chal_valid, auth_ok}), CW'(3'b100));
      chk(dom_en == exp_en(pol_cfg, 0, none), "R8 no grant on timeout", CW'(dom_en), CW'(exp_en(pol_cfg, 0, none)));

      id_check_en = idc;
      exchange(m, 1, idc ? DEV : DEV ^ 16'h00F0, TOUT - 1, rnd ^ 128'hA);
      chk(auth_ok && !err, "R7 R8 pass at last allowed cycle", CW'({auth_ok, err}), CW'(2'b10));
      chk(dom_en == exp_en(pol_cfg, 1, m), "R3 grant by policy and mask", CW'(dom_en), CW'(exp_en(pol_cfg, 1, m)));

      @(negedge clk) start_req = 1;
      @(negedge clk) start_req = 0;
      chk(rng_req == 1'b0, "R9 start ignored when authenticated", CW'(rng_req), 0);
      repeat (5) @(negedge clk);
      chk(auth_ok && dom_en == exp_en(pol_cfg, 1, m), "R9 grants kept", CW'(dom_en), CW'(exp_en(pol_cfg, 1, m)));
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule